// File: doc/BRIEF.md
# Printer port register interface

This block gives a host a small byte-wide register window onto a printer port. The port can drive data only or work in both directions. The host reaches the block over a simple bus with a 3-bit address, a write strobe and a read strobe. Three registers are mapped in this window: data, status and control. The block holds a model of an attached printer, so driver software can run its usual strobe and acknowledge protocol without real pin timing.

When a control write takes the strobe bit from low to high, the block captures the current data byte and offers it on a valid/ready output stream. The printer's busy and acknowledge bits do not follow a clock. Each status read moves them one step. A level interrupt output follows an internal pending flag. The flag is set by a control write that drives strobe low while interrupts are enabled, and it is cleared by a status read.

Read data is combinational from the address and the stored state. Side effects of a read take place on the clock edge at which `rd_en` is high. When `wr_en` and `rd_en` are high in the same cycle, the write is applied and the read has no side effect.

Top module: `prn_port_regs`

## Requirements
- R1: The low 3 address bits select a register: 0 is data, 1 is status and 2 is control. A read of offsets 3 to 7 returns 0xFF. A write to status or to offsets 3 to 7 changes no register.
- R2: Reset sets both data latches to 0xFF, status to 0xD9 and control to 0xCC, and clears the interrupt flag, the stream valid and the overflow flag.
- R3: Every control write stores the written byte with bits 7:6 forced to 1, and control reads return the stored value. Control bits: 5 direction (1 = input), 4 interrupt enable, 3 select-in, 2 init, 1 auto-linefeed, 0 strobe.
- R4: A control write with bit 2 at 0 loads status with 0xD8. Status bits: 7 busy (inverted), 6 ack, 5 paper out, 4 online, 3 error (inverted), 0 timeout.
- R5: A control write with bits 2, 3 and 0 all at 1 clears status bit 7. If the stored strobe bit was 0 before that write, the block also emits the last written data byte once on the stream.
- R6: A control write with bits 2 and 3 at 1 and bit 0 at 0 sets the interrupt flag, but only when the control value stored before that write has bit 4 set. The `irq` output equals the flag from the next clock edge on.
- R7: A status read returns the status and clears the interrupt flag. If status bit 7 is 0 and the stored strobe bit is 0, the read then advances the handshake: with ack set it clears ack, and otherwise it sets both ack and busy.
- R8: A data read returns the input latch when control bit 5 is 1, and the last written data byte otherwise. `in_load` loads `in_data` into the input latch.
- R9: An emitted byte stays on `pr_data` with `pr_valid` high until `pr_ready` is seen. A byte emitted while an unaccepted byte is held is dropped, and `pr_overflow` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| in_data | input | 8 | Byte from the port pins in input direction |
| in_load | input | 1 | Loads in_data into the input latch |
| irq | output | 1 | Interrupt level |
| pr_valid | output | 1 | Printed byte available |
| pr_data | output | 8 | Printed byte |
| pr_ready | input | 1 | Consumer accepts the printed byte |
| pr_overflow | output | 1 | Sticky flag: a printed byte was dropped |

## Verification
An error in the stored strobe or busy bit shows on the very next status read as a wrong handshake value. Such an error also shows on the stream, as a missing or doubled byte, in the cycle after the control write. A wrong interrupt-flag state appears on `irq` one edge after the control write or status read that should have changed it. A broken hold of the output stream shows as a changed `pr_data` or a raised overflow flag while the consumer stalls. The bench walks a full print handshake through the status register, then stalls the consumer to force a drop.

// File: rtl/prn_port_regs.sv
module prn_port_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] in_data,
  input  logic       in_load,
  output logic       irq,
  output logic       pr_valid,
  output logic [7:0] pr_data,
  input  logic       pr_ready,
  output logic       pr_overflow
);
  logic [7:0] dat_out, dat_in, stat, ctrl;
  logic       pend;

  wire [7:0] cv      = wdata | 8'hC0;
  wire       ctrl_wr = wr_en && addr == 3'd2;
  wire       stat_rd = rd_en && !wr_en && addr == 3'd1;
  wire       armed   = cv[2] && cv[3];
  wire       emit    = ctrl_wr && armed && cv[0] && !ctrl[0];

  always_comb begin
    case (addr)
      3'd0:    rdata = ctrl[5] ? dat_in : dat_out;
      3'd1:    rdata = stat;
      3'd2:    rdata = ctrl;
      default: rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_out <= 8'hFF;
      dat_in  <= 8'hFF;
      stat    <= 8'hD9;
      ctrl    <= 8'hCC;
      pend    <= 1'b0;
    end else begin
      if (in_load) dat_in <= in_data;
      if (wr_en && addr == 3'd0) dat_out <= wdata;
      if (ctrl_wr) begin
        ctrl <= cv;
        if (!cv[2]) stat <= 8'hD8;
        else if (cv[3] && cv[0]) stat[7] <= 1'b0;
        if (armed && !cv[0] && ctrl[4]) pend <= 1'b1;
      end else if (stat_rd) begin
        pend <= 1'b0;
        if (!stat[7] && !ctrl[0]) begin
          if (stat[6]) stat[6] <= 1'b0;
          else begin
            stat[6] <= 1'b1;
            stat[7] <= 1'b1;
          end
        end
      end
    end
  end

  assign irq = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_valid    <= 1'b0;
      pr_data     <= 8'h00;
      pr_overflow <= 1'b0;
    end else if (emit) begin
      if (pr_valid && !pr_ready) pr_overflow <= 1'b1;
      else begin
        pr_valid <= 1'b1;
        pr_data  <= dat_out;
      end
    end else if (pr_valid && pr_ready) begin
      pr_valid <= 1'b0;
    end
  end
endmodule

module prn_port_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] stat,
  input logic       irq,
  input logic       pr_valid,
  input logic [7:0] pr_data,
  input logic       pr_ready,
  input logic       pr_overflow
);
  p_unmapped_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > 3'd2) |-> rdata == 8'hFF);
  p_ctrl_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd2) |-> rdata[7:6] == 2'b11);
  p_init_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && !wdata[2]) |=> stat == 8'hD8);
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 3'd1) |=> !irq);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && !pr_ready) |=> pr_valid && $stable(pr_data));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pr_overflow |=> pr_overflow);
endmodule

bind prn_port_regs prn_port_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .stat(stat), .irq(irq), .pr_valid(pr_valid),
  .pr_data(pr_data), .pr_ready(pr_ready), .pr_overflow(pr_overflow)
);

// File: tb/tb_prn_port_regs.sv
module tb_prn_port_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, in_load = 1'b0, pr_ready = 1'b0;
  logic [7:0] wdata = 8'h00, in_data = 8'h00;
  logic [7:0] rdata, pr_data;
  logic       irq, pr_valid, pr_overflow;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prn_port_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .in_data(in_data), .in_load(in_load),
    .irq(irq), .pr_valid(pr_valid), .pr_data(pr_data), .pr_ready(pr_ready),
    .pr_overflow(pr_overflow)
  );

  // {is_read, addr, wdata, expected read}: covers R1 R3 R4 R5 R7 R8
  localparam logic [19:0] VEC [0:23] = '{
    20'h900D9, 20'hA00CC, 20'h800FF, 20'hB00FF, 20'h04100, 20'h80041,
    20'h20D00, 20'hA00CD, 20'h90059, 20'h90059, 20'h20C00, 20'h90059,
    20'h90019, 20'h900D9, 20'h20800, 20'h900D8, 20'hA00C8, 20'h10000,
    20'h900D8, 20'h71200, 20'h23C00, 20'h800FF, 20'h21C00, 20'h80041
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] v;
    do_reset();
    chk("R2 irq after reset", {7'd0, irq}, 8'h00);
    chk("R2 valid after reset", {7'd0, pr_valid}, 8'h00);
    pr_ready = 1'b1;
    for (int i = 0; i < 24; i++) begin
      if (VEC[i][19]) begin
        rd(VEC[i][18:16], v);
        chk($sformatf("table vector %0d R1 R3 R4 R5 R7 R8", i), v, VEC[i][7:0]);
      end else wr(VEC[i][18:16], VEC[i][15:8]);
    end

    do_reset();
    pr_ready = 1'b0;
    wr(3'd0, 8'h55);
    wr(3'd2, 8'h0D);
    chk("R5 emit valid", {7'd0, pr_valid}, 8'h01);
    chk("R5 emit data", pr_data, 8'h55);
    wr(3'd2, 8'h0D);
    chk("R5 no repeat emit", {7'd0, pr_overflow}, 8'h00);
    wr(3'd2, 8'h0C);
    wr(3'd0, 8'h66);
    wr(3'd2, 8'h0D);
    chk("R9 overflow set", {7'd0, pr_overflow}, 8'h01);
    chk("R9 held data", pr_data, 8'h55);
    @(negedge clk); pr_ready = 1'b1;
    @(negedge clk); pr_ready = 1'b0;
    chk("R9 accepted", {7'd0, pr_valid}, 8'h00);
    chk("R9 overflow sticky", {7'd0, pr_overflow}, 8'h01);

    wr(3'd2, 8'h1C);
    chk("R6 no irq without stored enable", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'h1C);
    chk("R6 irq set", {7'd0, irq}, 8'h01);
    rd(3'd1, v);
    chk("R7 irq cleared by status read", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'h18);
    chk("R6 no irq with init low", {7'd0, irq}, 8'h00);
    rd(3'd1, v);
    chk("R4 status after init low", v, 8'hD8);

    @(negedge clk); in_data = 8'hA5; in_load = 1'b1;
    @(negedge clk); in_load = 1'b0;
    wr(3'd2, 8'h2C);
    rd(3'd0, v);
    chk("R8 input latch", v, 8'hA5);
    wr(3'd2, 8'h0C);
    rd(3'd0, v);
    chk("R8 output latch", v, 8'h66);
    wr(3'd5, 8'h00);
    rd(3'd2, v);
    chk("R1 write to offset 5 ignored", v, 8'hCC);

    do_reset();
    rd(3'd1, v); chk("R2 status reset", v, 8'hD9);
    rd(3'd2, v); chk("R2 control reset", v, 8'hCC);
    rd(3'd0, v); chk("R2 data reset", v, 8'hFF);
    chk("R2 overflow reset", {7'd0, pr_overflow}, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule